// File: doc/BRIEF.md
# Real-time periodic interrupt timer

This block produces a periodic time-out. A single control byte selects the length of the period. The top bit picks one of two families of prescaler divide values: powers of two or decimal steps. A 3-bit rate field picks the prescale divide. A 4-bit modulus field multiplies the prescaled period by (modulus + 1), which gives finer control over the length. Each time a period ends, a sticky flag is raised. The interrupt output is that flag gated by an enable bit, and software clears the flag by writing a one to it.

The block runs on one system clock. The two counting sources arrive as single-cycle tick enables: an internal reference tick and an oscillator tick. A select input chooses between them. An oscillator-stable input reports whether the oscillator tick can be trusted. Stop and pseudo-stop inputs decide whether counting continues during low-power modes.

A small state machine decides in every cycle whether the counters advance, hold, or are forced to zero. Its four states are:
- OFF: binary family with rate 0.
- RUN
- HALT: stop mode without the pseudo-stop-on-oscillator exemption.
- OSCWAIT: oscillator selected but not stable.

Its transitions are:
- ENABLE: OFF to RUN.
- DISABLE: any state to OFF.
- SLEEP: RUN to HALT.
- WAKE: HALT to RUN.
- OSC_LOST: RUN or HALT to OSCWAIT.
- OSC_BACK: OSCWAIT to RUN or HALT.

The state machine evaluates these transitions in every cycle, and its decision takes effect in that same cycle.

Top module: `rti_timer`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00. The status register (address 1) reads 0x00, and `irq` is low.
- R2: Address 0 holds the control byte and is readable and writable at any time. Bit 7 selects the divider family (0 = binary, 1 = decimal), bits 6:4 hold the rate, and bits 3:0 hold the modulus. Address 1 is the status register: bit 7 is the flag and bit 0 is the interrupt enable.
- R3: In the binary family with a rate from 1 to 7, a period lasts (modulus+1) × 2^(9+rate) source ticks.
- R4: In the binary family with rate 0, the timer is disabled and never sets the flag.
- R5: In the decimal family, a period lasts (modulus+1) × D source ticks. D is 1000, 2000, 5000, 10000, 20000, 50000, 100000 or 200000 for rates 0 to 7.
- R6: Every write to address 0 restarts the period from zero, even when the written value is unchanged.
- R7: `clk_sel`=1 counts `osc_tick` and `clk_sel`=0 counts `irc_tick`. Any change of `clk_sel` restarts the period.
- R8: While `stop_mode` is high, counting halts and the count is kept. The one exception is when both `pseudo_stop` and `clk_sel` are high, in which case counting continues. When stop mode ends, counting resumes from the kept count.
- R9: While the oscillator is selected and `osc_ok` is low, counting stops and the count is held at zero. When `osc_ok` returns, a full period starts.
- R10: The flag stays set until software writes 1 to status bit 7. A period end in the same cycle as that write wins over the clear. `irq` is high when the flag and the enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address (0 control, 1 status) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 8 | Read data of the addressed register |
| irc_tick | input | 1 | Internal reference source tick |
| osc_tick | input | 1 | Oscillator source tick |
| clk_sel | input | 1 | Source select, 1 = oscillator |
| osc_ok | input | 1 | Oscillator stable status |
| stop_mode | input | 1 | Stop mode request |
| pseudo_stop | input | 1 | Pseudo-stop qualifier |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures exact period lengths for several binary and decimal settings. A design that swapped the divider families or dropped the modulus term would give the wrong cycle count.

It rewrites an unchanged control value partway through a period and switches the source partway through a period. A design that restarted only on a changed value, or ignored the source change, would raise the flag early.

It drops the oscillator-stable signal partway through a period and expects a full period afterwards, which catches a design that merely pauses. Stop mode is checked three ways:
- On the reference source, stop mode must hold the count rather than clear it.
- Pseudo-stop on the reference source must still halt.
- Pseudo-stop on the oscillator source must keep counting.

// File: rtl/rti_pkg.sv
package rti_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_RUN,
        ST_HALT,
        ST_OSCWAIT
    } rti_state_t;

    // decimal-family prescale divides, indexed by the rate field
    function automatic int unsigned dec_div(input logic [2:0] rate);
        int unsigned d;
        unique case (rate)
            3'd0: d = 1000;
            3'd1: d = 2000;
            3'd2: d = 5000;
            3'd3: d = 10000;
            3'd4: d = 20000;
            3'd5: d = 50000;
            3'd6: d = 100000;
            default: d = 200000;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rti_fsm.sv
module rti_fsm
    import rti_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic disabled,
    input  logic use_osc,
    input  logic osc_ok,
    input  logic stop_req,
    input  logic pstop_req,
    output logic run,
    output logic hold_zero
);

    rti_state_t state_q;
    rti_state_t nxt;

    // transition decision, effective in the current cycle
    always_comb begin
        if (disabled)
            nxt = ST_OFF;
        else if (use_osc && !osc_ok)
            nxt = ST_OSCWAIT;
        else if (stop_req && !(pstop_req && use_osc))
            nxt = ST_HALT;
        else
            nxt = ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= nxt;
    end

    always_comb begin
        run       = 1'b0;
        hold_zero = 1'b0;
        unique case (nxt)
            ST_RUN:     run = 1'b1;
            ST_OSCWAIT: hold_zero = 1'b1;
            ST_HALT:    ;
            ST_OFF:     ;
        endcase
    end

    // R8
    halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> $past(stop_req));

    // R9
    oscwait_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OSCWAIT) |-> $past(use_osc && !osc_ok));

endmodule

// File: rtl/rti_prescaler.sv
module rti_prescaler #(
    parameter int PRE_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [PRE_W-1:0] div,
    output logic             term
);

    logic [PRE_W-1:0] cnt_q;

    assign term = en && !clr && (cnt_q == div - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (en)
            cnt_q <= term ? '0 : cnt_q + 1'b1;
    end

    // R6
    pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R8
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(cnt_q));

    // R3
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div != '0) |-> (cnt_q < div));

endmodule

// File: rtl/rti_modcount.sv
module rti_modcount #(
    parameter int MOD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [MOD_W-1:0] modv,
    output logic             wrap
);

    logic [MOD_W-1:0] cnt_q;

    assign wrap = step && (cnt_q == modv);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (step)
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    // R6
    mod_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R5
    mod_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(cnt_q));

endmodule

// File: rtl/rti_timer.sv
module rti_timer
    import rti_pkg::*;
#(
    parameter int RATE_W    = 3,
    parameter int MOD_W     = 4,
    parameter int BIN_SHIFT = 9,
    parameter int PRE_W     = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_addr,
    input  logic [RATE_W+MOD_W:0]     wr_data,
    input  logic                      rd_addr,
    output logic [RATE_W+MOD_W:0]     rd_data,
    input  logic                      irc_tick,
    input  logic                      osc_tick,
    input  logic                      clk_sel,
    input  logic                      osc_ok,
    input  logic                      stop_mode,
    input  logic                      pseudo_stop,
    output logic                      irq
);

    localparam int CTRL_W = 1 + RATE_W + MOD_W;
    localparam int FAM_B  = CTRL_W - 1;

    logic [CTRL_W-1:0] ctrl_q;
    logic              flag_q;
    logic              ie_q;
    logic              sel_q;
    logic              osc_q;

    logic              wr_ctrl, wr_stat;
    logic              restart, disabled, src_tick;
    logic              run, hold_zero, clr, pre_en, pre_term, expire;
    logic [RATE_W-1:0] rate;
    logic [MOD_W-1:0]  modv;
    logic [PRE_W-1:0]  div;
    logic              unused_wr_bits;

    assign rate    = ctrl_q[MOD_W +: RATE_W];
    assign modv    = ctrl_q[MOD_W-1:0];
    assign wr_ctrl = wr_en && !wr_addr;
    assign wr_stat = wr_en && wr_addr;
    assign unused_wr_bits = ^wr_data[CTRL_W-2:1];

    assign disabled = !ctrl_q[FAM_B] && (rate == '0);
    assign src_tick = clk_sel ? osc_tick : irc_tick;
    assign restart  = wr_ctrl || (clk_sel != sel_q) || (clk_sel && osc_q && !osc_ok);
    assign clr      = restart || hold_zero;
    assign pre_en   = run && src_tick;

    always_comb begin
        if (ctrl_q[FAM_B])
            div = PRE_W'(dec_div(3'(rate)));
        else
            div = {{(PRE_W-1){1'b0}}, 1'b1} << (BIN_SHIFT + int'(rate));
    end

    rti_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .disabled  (disabled),
        .use_osc   (clk_sel),
        .osc_ok    (osc_ok),
        .stop_req  (stop_mode),
        .pstop_req (pseudo_stop),
        .run       (run),
        .hold_zero (hold_zero)
    );

    rti_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (pre_en),
        .div   (div),
        .term  (pre_term)
    );

    rti_modcount #(.MOD_W(MOD_W)) u_mod (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (pre_term),
        .modv  (modv),
        .wrap  (expire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
            sel_q  <= 1'b0;
            osc_q  <= 1'b0;
        end else begin
            sel_q <= clk_sel;
            osc_q <= osc_ok;
            if (wr_ctrl)
                ctrl_q <= wr_data;
            if (wr_stat)
                ie_q <= wr_data[0];
            if (expire)
                flag_q <= 1'b1;
            else if (wr_stat && wr_data[FAM_B])
                flag_q <= 1'b0;
        end
    end

    assign rd_data = rd_addr ? {flag_q, {(CTRL_W-2){1'b0}}, ie_q} : ctrl_q;
    assign irq     = flag_q && ie_q;

    // R4
    off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disabled && !flag_q) |=> !flag_q);

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_stat && wr_data[FAM_B])) |=> flag_q);

    // R10
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(expire));

endmodule

// File: tb/sim_rti_timer.sv
`timescale 1ns/1ps
module sim_rti_timer;

    localparam int NV    = 9;
    localparam int LIMIT = 25000;
    localparam logic [7:0] VEC_CTRL [0:NV-1] = '{
        8'h10, 8'h13, 8'h20, 8'h40, 8'h80, 8'h84, 8'h90, 8'hA1, 8'hB0};
    localparam int VEC_EXP [0:NV-1] = '{
        1024, 4096, 2048, 8192, 1000, 5000, 2000, 10000, 10000};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       irc_tick = 1'b1;
    logic       osc_tick = 1'b0;
    logic       clk_sel = 1'b0;
    logic       osc_ok = 1'b1;
    logic       stop_mode = 1'b0;
    logic       pseudo_stop = 1'b0;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    initial forever begin
        @(negedge clk);
        osc_tick = ~osc_tick;
    end

    rti_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irc_tick(irc_tick), .osc_tick(osc_tick), .clk_sel(clk_sel),
        .osc_ok(osc_ok), .stop_mode(stop_mode), .pseudo_stop(pseudo_stop),
        .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    // write control, then clear the flag and enable the interrupt
    task automatic start(input logic [7:0] c);
        reg_write(1'b0, c);
        reg_write(1'b1, 8'h81);
    endtask

    task automatic measure(input int n0, output int n);
        n = n0;
        while (n < LIMIT) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (irq) break;
        end
    endtask

    function automatic bit near(input int a, input int e, input int tol);
        return (a >= e - tol) && (a <= e + tol);
    endfunction

    initial begin
        #(3_600_000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_addr = 1'b0; #1;
        chk(rd_data == 8'h00, "R1 ctrl", rd_data, 0);
        rd_addr = 1'b1; #1;
        chk(rd_data == 8'h00, "R1 status", rd_data, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);

        // R2 readback
        reg_write(1'b0, 8'hA5);
        @(negedge clk); rd_addr = 1'b0; #1;
        chk(rd_data == 8'hA5, "R2 ctrl readback", rd_data, 8'hA5);

        // R4 binary rate 0 disabled
        start(8'h00);
        repeat (3000) @(posedge clk);
        @(negedge clk);
        chk(irq == 1'b0, "R4 disabled", irq, 0);

        // R3 / R5 period table on the reference source
        for (int i = 0; i < NV; i++) begin
            start(VEC_CTRL[i]);
            measure(1, n);
            chk(n == VEC_EXP[i], VEC_CTRL[i][7] ? "R5 decimal period" : "R3 binary period",
                n, VEC_EXP[i]);
        end

        // R10 sticky flag, enable gating and write-one-to-clear
        repeat (50) @(posedge clk);
        @(negedge clk);
        chk(irq == 1'b1, "R10 sticky", irq, 1);
        reg_write(1'b1, 8'h00);
        @(negedge clk); rd_addr = 1'b1; #1;
        chk(irq == 1'b0, "R10 enable gate", irq, 0);
        chk(rd_data == 8'h80, "R10 flag kept", rd_data, 8'h80);
        reg_write(1'b1, 8'h81);
        @(negedge clk); #1;
        chk(rd_data == 8'h01, "R10 cleared", rd_data, 1);

        // R6 rewrite same value restarts
        start(8'h10);
        repeat (699) @(posedge clk);
        reg_write(1'b0, 8'h10);
        measure(0, n);
        chk(n == 1024, "R6 restart on write", n, 1024);

        // R8 stop holds count on the reference source
        start(8'h10);
        repeat (499) @(posedge clk);
        @(negedge clk); stop_mode = 1'b1;
        repeat (3000) @(posedge clk);
        @(negedge clk);
        chk(irq == 1'b0, "R8 halted", irq, 0);
        stop_mode = 1'b0;
        measure(0, n);
        chk(near(n, 524, 1), "R8 resume keeps count", n, 524);

        // R8 pseudo-stop on the reference source still halts
        stop_mode = 1'b1; pseudo_stop = 1'b1;
        start(8'h10);
        repeat (2000) @(posedge clk);
        @(negedge clk);
        chk(irq == 1'b0, "R8 pseudo on reference halts", irq, 0);
        stop_mode = 1'b0; pseudo_stop = 1'b0;

        // R7 source change restarts, oscillator ticks half rate
        start(8'h10);
        repeat (600) @(posedge clk);
        @(negedge clk); clk_sel = 1'b1;
        measure(0, n);
        chk(near(n, 2048, 3), "R7 select change restart", n, 2048);

        // R8 pseudo-stop with oscillator keeps counting
        stop_mode = 1'b1; pseudo_stop = 1'b1;
        start(8'h10);
        measure(1, n);
        chk(near(n, 2048, 3), "R8 pseudo on oscillator runs", n, 2048);
        stop_mode = 1'b0; pseudo_stop = 1'b0;

        // R9 oscillator loss clears and waits
        start(8'h10);
        repeat (1000) @(posedge clk);
        @(negedge clk); osc_ok = 1'b0;
        repeat (300) @(posedge clk);
        @(negedge clk);
        chk(irq == 1'b0, "R9 no count while unstable", irq, 0);
        osc_ok = 1'b1;
        measure(0, n);
        chk(near(n, 2048, 3), "R9 full period after recovery", n, 2048);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule